// File: doc/BRIEF.md
# Two-Miss Hysteresis Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of small per-branch records, selected by a few low bits of the program counter. Each record holds two bits: a predicted direction and a flag that says whether the previous prediction for that record turned out right. The fetch stage presents an address on the lookup port and gets the predicted direction back in the same cycle, through combinational logic only.

Branches are resolved later, in the execute stage. When the execute stage resolves one, it drives the update port with the branch address and the real outcome, and the addressed record is rewritten on the next clock edge. The predicted direction changes only after two wrong predictions in a row. A loop branch that falls through once at exit therefore still predicts taken when the loop is entered again.

Top module: `hyst_branch_predictor`

## Requirements
- R1: After reset, every record predicts not taken (lookup output 0) and holds its "last prediction right" flag at 1.
- R2: The lookup output is combinational and in the same cycle reflects the record chosen by PC bits [7:2] (default 64 records). PC bits [1:0] and bits above 7 do not affect the choice, so addresses that differ only in those bits share one record.
- R3: An update whose outcome equals the stored direction keeps that direction and sets the flag to 1.
- R4: An update whose outcome differs from the stored direction while the flag is 1 keeps the direction and clears the flag to 0.
- R5: An update whose outcome differs from the stored direction while the flag is 0 inverts the direction and sets the flag to 1.
- R6: After a flip, one further wrong outcome does not flip the direction back.
- R7: When the update-valid input is 0, the update address and outcome inputs have no effect on any record.
- R8: An update changes only the record selected by its own address.
- R9: When a lookup and an update select the same record in one cycle, the lookup returns the value from before the update. The new value is visible from the cycle after the clock edge.
- R10: For a loop branch taken ten times and then not taken once, repeated, the record predicts taken on the first iteration of the second pass and on every iteration of that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Resolved branch present this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Real outcome, 1 = taken |

## Verification
A single record is driven through an agreeing outcome, one disagreeing outcome and then a second disagreeing outcome. This separates the keep-on-first-miss path from the flip-on-second-miss path, and a later single miss shows that the flag was set again after the flip. A repeated loop pattern (ten taken, one not taken) checks the fall-through case that motivates the hysteresis. Aliased and neighbouring addresses, updates with valid held low, and a lookup that hits the record being written in the same cycle separate index decoding, write gating and read-before-write ordering. A closing sweep of all records against a bench model catches any stray write.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef struct packed {
    logic dir;   // predicted direction, 1 = taken
    logic ok;    // last prediction for this record was right
  } bp_entry_t;

  localparam bp_entry_t BP_RESET = '{dir: 1'b0, ok: 1'b1};

  // Two-miss hysteresis rule.
  function automatic bp_entry_t bp_next(input bp_entry_t cur, input logic taken);
    bp_entry_t n;
    unique case ({taken == cur.dir, cur.ok})
      2'b10, 2'b11: n = '{dir: cur.dir, ok: 1'b1};   // agreed
      2'b01:        n = '{dir: cur.dir, ok: 1'b0};   // first miss
      default:      n = '{dir: taken,   ok: 1'b1};   // second miss: flip
    endcase
    return n;
  endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  assign idx = pc[IDX_LSB +: IDX_W];
endmodule

// File: rtl/bp_next_state.sv
module bp_next_state
  import bp_pkg::*;
(
  input  bp_entry_t cur,
  input  logic      taken,
  output bp_entry_t nxt,
  output logic      miss,
  output logic      flip
);
  assign nxt  = bp_next(cur, taken);
  assign miss = (taken != cur.dir);
  assign flip = (nxt.dir != cur.dir);
endmodule

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output bp_entry_t        rd_entry,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output bp_entry_t        wr_old,
  input  bp_entry_t        wr_new
);
  logic [ENTRIES-1:0] dir_q, ok_q;
  logic [ENTRIES-1:0] sel;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_sel
    assign sel[i] = wr_en && (wr_idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= {ENTRIES{BP_RESET.dir}};
      ok_q  <= {ENTRIES{BP_RESET.ok}};
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (sel[i]) begin
          dir_q[i] <= wr_new.dir;
          ok_q[i]  <= wr_new.ok;
        end
      end
    end
  end

  assign rd_entry = '{dir: dir_q[rd_idx], ok: ok_q[rd_idx]};
  assign wr_old   = '{dir: dir_q[wr_idx], ok: ok_q[wr_idx]};

  // Rule checks against stored state.
  p_agree_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken == wr_old.dir) |=>
      (dir_q[$past(wr_idx)] == $past(wr_taken)) && ok_q[$past(wr_idx)]);

  p_first_miss_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken != wr_old.dir && wr_old.ok) |=>
      (dir_q[$past(wr_idx)] == $past(wr_old.dir)) && !ok_q[$past(wr_idx)]);

  p_second_miss_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken != wr_old.dir && !wr_old.ok) |=>
      (dir_q[$past(wr_idx)] == $past(wr_taken)) && ok_q[$past(wr_idx)]);

  p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dir_q) && $stable(ok_q));

  p_one_record_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $countones((dir_q ^ $past(dir_q)) | (ok_q ^ $past(ok_q))) <= 1);
endmodule

// File: rtl/hyst_branch_predictor.sv
module hyst_branch_predictor
  import bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64,
  parameter int IDX_LSB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] lk_idx, up_idx;
  bp_entry_t        lk_entry, up_old, up_new;
  logic             up_miss, up_flip;

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_lk_idx (
    .pc(lk_pc), .idx(lk_idx));
  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_up_idx (
    .pc(up_pc), .idx(up_idx));

  bp_next_state u_next (
    .cur(up_old), .taken(up_taken), .nxt(up_new),
    .miss(up_miss), .flip(up_flip));

  bp_table #(.ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_entry(lk_entry),
    .wr_en(up_valid), .wr_idx(up_idx), .wr_taken(up_taken),
    .wr_old(up_old), .wr_new(up_new));

  assign lk_taken = lk_entry.dir;

  // A flip needs a miss on a record whose flag was already cleared.
  p_flip_needs_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_flip) |-> (up_miss && !up_old.ok));

  // Same-record lookup during a write sees the pre-write direction.
  p_read_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && lk_idx == up_idx) |-> (lk_taken == up_old.dir));
endmodule

// File: tb/tb_hyst_branch_predictor.sv
module tb_hyst_branch_predictor;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model: direction and "last right" flag per record.
  bit m_dir [N];
  bit m_ok  [N];

  always #5 clk = ~clk;

  hyst_branch_predictor dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  function automatic int ix(input logic [31:0] pc);
    return int'((pc >> 2) % N);
  endfunction

  function automatic void model_upd(input logic [31:0] pc, input bit t);
    int k = ix(pc);
    if (t == m_dir[k]) m_ok[k] = 1;
    else if (m_ok[k]) m_ok[k] = 0;
    else begin m_dir[k] = t; m_ok[k] = 1; end
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic look(input string req, input logic [31:0] pc, input bit exp);
    @(negedge clk);
    lk_pc = pc;
    #1;
    check(req, lk_taken, exp);
  endtask

  task automatic upd(input logic [31:0] pc, input bit t);
    @(negedge clk);
    up_valid = 1; up_pc = pc; up_taken = t;
    @(posedge clk);
    model_upd(pc, t);
    #1 up_valid = 0;
  endtask

  task automatic t_reset;
    look("R1", 32'h0000_0000, 0);
    look("R1", 32'h0000_00FC, 0);
    look("R1", 32'h0000_0080, 0);
    // flag at 1 after reset: one miss must not flip
    upd(32'h0000_0040, 1);
    look("R1", 32'h0000_0040, 0);
  endtask

  task automatic t_rule;
    logic [31:0] a = 32'h0000_1010;
    upd(a, 0); look("R3", a, 0);
    upd(a, 1); look("R4", a, 0);
    upd(a, 1); look("R5", a, 1);
    look("R8", a + 4, 0);
    look("R8", a - 4, 0);
    upd(a, 0); look("R6", a, 1);
    upd(a, 1); look("R3", a, 1);
    upd(a, 0); look("R6", a, 1);
  endtask

  task automatic t_alias;
    // 0x1013 and 0x5110 both select record 4, like 0x1010
    look("R2", 32'h0000_1013, m_dir[4]);
    look("R2", 32'h0000_5110, m_dir[4]);
    upd(32'h0000_5111, 0);
    upd(32'h0000_1012, 0);
    look("R2", 32'h0000_1010, 0);
  endtask

  task automatic t_idle;
    logic [31:0] b = 32'h0000_2030;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      up_valid = 0; up_pc = b; up_taken = 1;
      @(posedge clk);
    end
    #1;
    look("R7", b, 0);
    upd(b, 1);            // would flip now only if the idle cycles had counted
    look("R7", b, 0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] c = 32'h0000_3044;
    upd(c, 1);            // flag cleared
    @(negedge clk);
    lk_pc = c; up_valid = 1; up_pc = c; up_taken = 1;
    #1 check("R9", lk_taken, 0);
    @(posedge clk);
    model_upd(c, 1);
    #1 up_valid = 0;
    #1 check("R9", lk_taken, 1);
  endtask

  task automatic t_loop;
    logic [31:0] p = 32'h0000_2020;
    for (int pass = 0; pass < 2; pass++) begin
      for (int it = 0; it < 11; it++) begin
        bit outc = (it < 10);
        if (pass == 1) look("R10", p, 1);
        else look("R10", p, m_dir[ix(p)]);
        upd(p, outc);
      end
    end
    look("R10", p, 1);
  endtask

  task automatic t_sweep;
    for (int k = 0; k < N; k++) look("R8", 32'(k * 4), m_dir[k]);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin m_dir[k] = 0; m_ok[k] = 1; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_rule();
    t_alias();
    t_idle();
    t_same_cycle();
    t_loop();
    t_sweep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule